// File: doc/BRIEF.md
# Soft-Switch Memory Bank Controller

This block sits on the 16-bit address bus of an 8-bit processor. It holds the four mode flags that steer a memory router: read from RAM or ROM, write to RAM enabled or disabled, which of the two 4 KB banks the low window maps to, and whether zero page and stack come from the alternate memory. Software changes these flags by touching fixed I/O addresses. The banking switches act on bus reads. The alternate zero-page switch acts on bus writes.

The write-enabling switches need two reads of the same address, one straight after the other, before they take effect. This guards against a single stray access enabling writes. The block remembers the address of the last valid bus cycle, read or write, for this purpose. Three status addresses report one flag each in bit 7 of the read data. The memory arrays are not part of this block.

Top module: `softswitch_bank_ctl`

## Requirements
- R1: After reset the flags are ram_read=0, ram_write=0, bank_two=0 and alt_zp=0.
- R2: A single read of an even banking switch loads the flags on the next clock edge. 0xC080 loads read-RAM, no write, bank two. 0xC082 loads ROM, no write, bank two. 0xC088 loads read-RAM, no write, bank one. 0xC08A loads ROM, no write, bank one.
- R3: A read of an odd banking switch loads the flags only if the previous valid bus cycle used the same address. 0xC081 loads ROM with writes and bank two. 0xC083 loads RAM with writes and bank two. 0xC089 loads ROM with writes and bank one. 0xC08B loads RAM with writes and bank one.
- R4: An odd-switch read whose previous bus cycle used another address leaves ram_read, ram_write and bank_two unchanged. This covers an intervening read or write, but not idle cycles.
- R5: A read of any banking switch address returns 0x00 on bus_rdata in the same cycle.
- R6: A read of 0xC011, 0xC012 or 0xC016 returns bank_two, ram_read or alt_zp respectively in bit 7 of bus_rdata, in the same cycle. The other bits are 0.
- R7: A write to 0xC008 sets alt_zp and a write to 0xC009 clears it. The other three flags do not change.
- R8: Banking switch reads never change alt_zp.
- R9: Writes to banking switch addresses, and reads of 0xC008 or 0xC009, change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus address |
| bus_rd | input | 1 | Valid read cycle |
| bus_wr | input | 1 | Valid write cycle |
| bus_rdata | output | 8 | Read data for switch and status addresses |
| ram_read | output | 1 | Low window reads come from RAM (0 = ROM) |
| ram_write | output | 1 | Low window writes reach RAM |
| bank_two | output | 1 | Second 4 KB bank selected |
| alt_zp | output | 1 | Zero page and stack from alternate memory |

## Verification
The assertions assume that bus_rd and bus_wr are never high in the same cycle. They also assume the address is stable for the whole cycle in which a strobe is high. The bench drives each access as one strobed cycle set up at the falling edge, followed by an idle cycle, so both assumptions always hold. Idle cycles do not count as bus cycles. The spacing therefore keeps two back-to-back reads of the same odd switch counted as consecutive, while an inserted status read or write breaks the pair.

// File: rtl/bank_sw_pkg.sv
package bank_sw_pkg;
    typedef struct packed {
        logic rd_ram;
        logic wr_en;
        logic bank2;
        logic alt_zp;
    } bank_mode_t;

    localparam bank_mode_t MODE_RESET = '{rd_ram: 1'b0, wr_en: 1'b0, bank2: 1'b0, alt_zp: 1'b0};
endpackage

// File: rtl/bank_sw_decode.sv
module bank_sw_decode #(
    parameter int          ADDR_W  = 16,
    parameter logic [15:0] LC_BASE = 16'hC080,
    parameter logic [15:0] ZP_ON   = 16'hC008,
    parameter logic [15:0] ZP_OFF  = 16'hC009
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] prev_addr,
    input  logic              prev_vld,
    output logic              lc_load,
    output logic              lc_rd_ram,
    output logic              lc_wr_en,
    output logic              lc_bank2,
    output logic              zp_set,
    output logic              zp_clr
);
    logic in_window;
    logic needs_pair;
    logic paired;

    always_comb begin
        // 16-byte window, lower half of each 8-byte group is decoded
        in_window  = (addr[ADDR_W-1:4] == LC_BASE[ADDR_W-1:4]) && !addr[2];
        needs_pair = addr[0];
        paired     = prev_vld && (prev_addr == addr);
        lc_load    = rd && in_window && (!needs_pair || paired);
        // bits[1:0]: 00 ram/no-wr, 01 rom/wr, 10 rom/no-wr, 11 ram/wr
        lc_rd_ram  = (addr[1] == addr[0]);
        lc_wr_en   = addr[0];
        lc_bank2   = !addr[3];
        zp_set     = wr && (addr == ZP_ON);
        zp_clr     = wr && (addr == ZP_OFF);
    end
endmodule

// File: rtl/bank_sw_state.sv
module bank_sw_state
    import bank_sw_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bus_valid,
    input  logic              lc_load,
    input  logic              lc_rd_ram,
    input  logic              lc_wr_en,
    input  logic              lc_bank2,
    input  logic              zp_set,
    input  logic              zp_clr,
    output bank_mode_t        mode,
    output logic [ADDR_W-1:0] prev_addr,
    output logic              prev_vld
);
    typedef struct packed {
        bank_mode_t        mode;
        logic [ADDR_W-1:0] prev_addr;
        logic              prev_vld;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lc_load) begin
            st_d.mode.rd_ram = lc_rd_ram;
            st_d.mode.wr_en  = lc_wr_en;
            st_d.mode.bank2  = lc_bank2;
        end
        if (zp_set) begin
            st_d.mode.alt_zp = 1'b1;
        end else if (zp_clr) begin
            st_d.mode.alt_zp = 1'b0;
        end
        if (bus_valid) begin
            st_d.prev_addr = addr;
            st_d.prev_vld  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode      <= MODE_RESET;
            st_q.prev_addr <= '0;
            st_q.prev_vld  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode      = st_q.mode;
    assign prev_addr = st_q.prev_addr;
    assign prev_vld  = st_q.prev_vld;
endmodule

// File: rtl/bank_sw_status.sv
module bank_sw_status
    import bank_sw_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter logic [15:0] ST_BANK2 = 16'hC011,
    parameter logic [15:0] ST_RDRAM = 16'hC012,
    parameter logic [15:0] ST_ALTZP = 16'hC016
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  bank_mode_t        mode,
    output logic [DATA_W-1:0] rdata
);
    localparam int FLAG_BIT = DATA_W - 1;

    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (addr)
                ST_BANK2: rdata[FLAG_BIT] = mode.bank2;
                ST_RDRAM: rdata[FLAG_BIT] = mode.rd_ram;
                ST_ALTZP: rdata[FLAG_BIT] = mode.alt_zp;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/softswitch_bank_ctl.sv
module softswitch_bank_ctl
    import bank_sw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ram_read,
    output logic              ram_write,
    output logic              bank_two,
    output logic              alt_zp
);
    logic              lc_load, lc_rd_ram, lc_wr_en, lc_bank2, zp_set, zp_clr;
    logic [ADDR_W-1:0] prev_addr;
    logic              prev_vld;
    bank_mode_t        mode;

    bank_sw_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr      (bus_addr),
        .rd        (bus_rd),
        .wr        (bus_wr),
        .prev_addr (prev_addr),
        .prev_vld  (prev_vld),
        .lc_load   (lc_load),
        .lc_rd_ram (lc_rd_ram),
        .lc_wr_en  (lc_wr_en),
        .lc_bank2  (lc_bank2),
        .zp_set    (zp_set),
        .zp_clr    (zp_clr)
    );

    bank_sw_state #(.ADDR_W(ADDR_W)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .bus_valid (bus_rd || bus_wr),
        .lc_load   (lc_load),
        .lc_rd_ram (lc_rd_ram),
        .lc_wr_en  (lc_wr_en),
        .lc_bank2  (lc_bank2),
        .zp_set    (zp_set),
        .zp_clr    (zp_clr),
        .mode      (mode),
        .prev_addr (prev_addr),
        .prev_vld  (prev_vld)
    );

    bank_sw_status #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stat (
        .addr  (bus_addr),
        .rd    (bus_rd),
        .mode  (mode),
        .rdata (bus_rdata)
    );

    assign ram_read  = mode.rd_ram;
    assign ram_write = mode.wr_en;
    assign bank_two  = mode.bank2;
    assign alt_zp    = mode.alt_zp;
endmodule

// File: rtl/bank_sw_checker.sv
module bank_sw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] bus_addr,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [7:0]  bus_rdata,
    input logic        ram_read,
    input logic        ram_write,
    input logic        bank_two,
    input logic        alt_zp
);
    logic [15:0] seen_q;
    logic        seen_vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q     <= '0;
            seen_vld_q <= 1'b0;
        end else if (bus_rd || bus_wr) begin
            seen_q     <= bus_addr;
            seen_vld_q <= 1'b1;
        end
    end

    logic back_to_back;
    logic lc_addr;
    assign back_to_back = seen_vld_q && (seen_q == bus_addr);
    assign lc_addr      = (bus_addr[15:4] == 12'hC08);

    a_in_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    a_r1_reset_default: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !ram_read && !ram_write && !bank_two && !alt_zp);

    a_r2_c080_ram_bank2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr == 16'hC080 |=> ram_read && !ram_write && bank_two);

    a_r3_c083_paired: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr == 16'hC083 && back_to_back |=> ram_read && ram_write && bank_two);

    a_r4_single_odd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && lc_addr && bus_addr[0] && !back_to_back
        |=> $stable({ram_read, ram_write, bank_two}));

    a_r5_switch_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && lc_addr |-> bus_rdata == 8'h00);

    a_r6_status_altzp: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr == 16'hC016 |-> bus_rdata == {alt_zp, 7'b0});

    a_r7_zp_on: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == 16'hC008 |=> alt_zp && $stable({ram_read, ram_write, bank_two}));

    a_r7_zp_off: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == 16'hC009 |=> !alt_zp && $stable({ram_read, ram_write, bank_two}));

    a_r8_lc_keeps_zp: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && lc_addr |=> $stable(alt_zp));

    a_r9_lc_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && lc_addr |=> $stable({ram_read, ram_write, bank_two, alt_zp}));
endmodule

bind softswitch_bank_ctl bank_sw_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .ram_read  (ram_read),
    .ram_write (ram_write),
    .bank_two  (bank_two),
    .alt_zp    (alt_zp)
);

// File: tb/tb_softswitch_bank_ctl.sv
module tb_softswitch_bank_ctl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_rdata;
    logic        ram_read, ram_write, bank_two, alt_zp;

    int total = 0;
    int bad   = 0;
    logic [7:0] rdv;

    always #(CLK_PERIOD/2) clk = ~clk;

    softswitch_bank_ctl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_rdata(bus_rdata), .ram_read(ram_read),
        .ram_write(ram_write), .bank_two(bank_two), .alt_zp(alt_zp)
    );

    // flags packed as {ram_read, ram_write, bank_two, alt_zp}
    task automatic chk_flags(string req, logic [3:0] exp);
        logic [3:0] act = {ram_read, ram_write, bank_two, alt_zp};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s flags act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic chk_data(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s rdata act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_rd(logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #(CLK_PERIOD/4);
        d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_wr(logic [15:0] a);
        @(negedge clk);
        bus_addr = a;
        bus_wr   = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic t_reset;
        chk_flags("R1", 4'b0000);
    endtask

    task automatic t_even;
        do_rd(16'hC080, rdv); chk_flags("R2", 4'b1010); chk_data("R5", rdv, 8'h00);
        do_rd(16'hC082, rdv); chk_flags("R2", 4'b0010);
        do_rd(16'hC088, rdv); chk_flags("R2", 4'b1000); chk_data("R5", rdv, 8'h00);
        do_rd(16'hC08A, rdv); chk_flags("R2", 4'b0000);
    endtask

    task automatic t_odd;
        do_rd(16'hC081, rdv); chk_flags("R4", 4'b0000); chk_data("R5", rdv, 8'h00);
        do_rd(16'hC081, rdv); chk_flags("R3", 4'b0110);
        do_rd(16'hC08B, rdv); chk_flags("R4", 4'b0110);
        do_rd(16'hC08B, rdv); chk_flags("R3", 4'b1100);
        do_rd(16'hC083, rdv);
        do_rd(16'hC083, rdv); chk_flags("R3", 4'b1110); chk_data("R5", rdv, 8'h00);
        do_rd(16'hC089, rdv);
        do_rd(16'hC089, rdv); chk_flags("R3", 4'b0100);
    endtask

    task automatic t_separated;
        do_rd(16'hC08A, rdv); chk_flags("R2", 4'b0000);
        do_rd(16'hC08B, rdv);
        do_rd(16'hC011, rdv);
        do_rd(16'hC08B, rdv); chk_flags("R4", 4'b0000);
        do_rd(16'hC083, rdv);
        do_wr(16'hC008);
        do_rd(16'hC083, rdv); chk_flags("R4", 4'b0001);
        do_wr(16'hC009);      chk_flags("R7", 4'b0000);
    endtask

    task automatic t_zp_and_status;
        do_rd(16'hC083, rdv);
        do_rd(16'hC083, rdv); chk_flags("R3", 4'b1110);
        do_wr(16'hC008);      chk_flags("R7", 4'b1111);
        do_rd(16'hC016, rdv); chk_data("R6", rdv, 8'h80);
        do_rd(16'hC011, rdv); chk_data("R6", rdv, 8'h80);
        do_rd(16'hC012, rdv); chk_data("R6", rdv, 8'h80);
        do_rd(16'hC08A, rdv); chk_flags("R8", 4'b0001);
        do_rd(16'hC011, rdv); chk_data("R6", rdv, 8'h00);
        do_rd(16'hC012, rdv); chk_data("R6", rdv, 8'h00);
        do_wr(16'hC009);      chk_flags("R7", 4'b0000);
        do_rd(16'hC016, rdv); chk_data("R6", rdv, 8'h00);
    endtask

    task automatic t_ignored;
        do_wr(16'hC080);      chk_flags("R9", 4'b0000);
        do_wr(16'hC08B);
        do_wr(16'hC08B);      chk_flags("R9", 4'b0000);
        do_rd(16'hC008, rdv); chk_flags("R9", 4'b0000); chk_data("R9", rdv, 8'h00);
        do_wr(16'hC008);
        do_rd(16'hC009, rdv); chk_flags("R9", 4'b0001);
        do_rd(16'hC080, rdv); chk_flags("R8", 4'b1011);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_even();
        t_odd();
        t_separated();
        t_zp_and_status();
        t_ignored();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        total++;
        bad++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule